// File: doc/BRIEF.md
# DDR3 ZQ Calibration Scheduler

This block lives inside a DDR3 memory controller and decides when impedance (ZQ) calibration commands go out to the DRAM. Leaving reset, and again after every qualified re-initialization, it raises one long calibration request. The command arbiter grants it, and the block then marks the command bus busy for the init calibration time. From then on, a timer counted in microseconds starts a calibration at a fixed period. A parameter makes these periodic calibrations short or long.

Each calibration is a request/grant exchange with the arbiter. The request and its `cmdType` stay steady until the grant arrives. A busy window of exact length follows, and its length depends on the kind of calibration. The periodic timer restarts at every grant. When a parameter enables it, a user request input can force a calibration early. A trigger that arrives while a calibration is still pending or busy joins that calibration and does not start a second one. A re-init input only takes effect when it stays high for a minimum run of cycles. While it takes effect, the block drops everything and stays silent until the input falls.

Window lengths are parameters. The init window is legal from 512 to 4095 cycles and defaults to 512. The short window is legal from 64 to 2047 cycles and defaults to 64. The long window is fixed at 256 cycles.

Top module: `zq_cal_sched`

## Requirements
- R1: While `rstN` is low, `calReq` and `calBusy` are 0. On the first clock edge after reset is released, `calReq` rises with `cmdType`=1 (long), and the calibration it grants uses the init window `T_ZQINIT`.
- R2: `cmdType` encodes 1 for long and 0 for short. Once `calReq` is high, it stays high with `cmdType` unchanged until a clock edge that samples `calGnt`=1. On that edge it falls.
- R3: `calBusy` is high for exactly W consecutive cycles, starting with the edge that samples the grant. W is `T_ZQINIT` for an init calibration, `T_ZQCS` for a short one and 256 for a long one.
- R4: When no other trigger comes, `calReq` rises on the clock edge that lies exactly `PERIOD_US`*`CYC_PER_US` cycles after the edge that granted the previous calibration. Its `cmdType` is given by `LONG_PERIODIC` (0 selects short, the default).
- R5: With `USER_CAL_EN`=1, a `userReq` sampled high while the block is idle raises `calReq` on that same edge, with the periodic type. With `USER_CAL_EN`=0, `userReq` has no effect.
- R6: A periodic or user trigger that comes while a request is pending or a window is busy joins that calibration and starts no second request. `calReq` and `calBusy` are never high together.
- R7: When `initReq` is sampled high on `REINIT_MIN` (default 4) consecutive edges, both `calReq` and `calBusy` are 0 from the next edge on, and they stay 0 while `initReq` remains high. A shorter run of `initReq` changes nothing: a window in progress runs to its full length, and the next periodic request keeps its time.
- R8: Once a qualified `initReq` is sampled low, `calReq` rises with `cmdType`=1 on the following edge. That calibration uses `T_ZQINIT`, and the timer is counted afresh from its grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| initReq | input | 1 | Re-initialization request, must be held to qualify |
| userReq | input | 1 | Forced calibration request (used when `USER_CAL_EN`=1) |
| calGnt | input | 1 | Grant from the command arbiter |
| calReq | output | 1 | Calibration request to the arbiter |
| cmdType | output | 1 | 1 = long, 0 = short; valid while `calReq` is high |
| calBusy | output | 1 | Calibration window in progress |

## Verification
The bench builds two instances, each with 4 cycles per microsecond and a 150 µs period, so a period is 600 cycles. That is longer than the 512-cycle minimum init window, so every window, request and re-init can be seen within a few thousand cycles. One instance keeps short periodic calibrations with the 64-cycle minimum short window and has the user port enabled. The other uses long periodic calibrations with the fixed 256-cycle window and has the user port disabled, so the same user pulses show up as ignored there. A random grant delay and random idle gaps vary where the user pulses and re-init pulses fall relative to the period and the windows.

// File: rtl/zq_sched_pkg.sv
package zq_sched_pkg;

  // fixed long-calibration window in clock cycles
  localparam int ZQ_OPER_CYC = 256;

  typedef enum logic [1:0] {
    WIN_INIT  = 2'd0,
    WIN_SHORT = 2'd1,
    WIN_LONG  = 2'd2
  } winSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    tmrClr;
    logic    winLoad;
    logic    winClr;
    winSel_e winSel;
  } ctrlStrobe_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/zq_dpath.sv
module zq_dpath
  import zq_sched_pkg::*;
#(
  parameter int CYC_PER_US = 400,
  parameter int PERIOD_US  = 200,
  parameter int T_ZQINIT   = 512,
  parameter int T_ZQCS     = 64,
  parameter int REINIT_MIN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        initReq,
  input  ctrlStrobe_t strobe,
  output logic        periodHit,
  output logic        winLast,
  output logic        qualHit,
  output logic        calBusy
);

  localparam int WIN_MAX = maxOf3(T_ZQINIT, T_ZQCS, ZQ_OPER_CYC);
  localparam int WIN_W   = $clog2(WIN_MAX + 1);
  localparam int PRE_W   = $clog2(CYC_PER_US + 1);
  localparam int US_W    = $clog2(PERIOD_US + 1);
  localparam int Q_W     = $clog2(REINIT_MIN + 1);

  logic [PRE_W-1:0] preCnt;
  logic [US_W-1:0]  usCnt;
  logic [WIN_W-1:0] winCnt;
  logic [Q_W-1:0]   qCnt;
  logic             usTick;
  logic [WIN_W-1:0] winLen;

  // microsecond prescaler and period counter
  assign usTick    = (preCnt == PRE_W'(CYC_PER_US - 1));
  assign periodHit = usTick && (usCnt == US_W'(PERIOD_US - 1));

  always_ff @(posedge clk) begin
    if (!rstN || strobe.tmrClr) begin
      preCnt <= '0;
      usCnt  <= '0;
    end else if (usTick) begin
      preCnt <= '0;
      usCnt  <= periodHit ? '0 : usCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // window length select
  always_comb begin
    unique case (strobe.winSel)
      WIN_INIT:  winLen = WIN_W'(T_ZQINIT);
      WIN_SHORT: winLen = WIN_W'(T_ZQCS);
      default:   winLen = WIN_W'(ZQ_OPER_CYC);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.winClr)
      winCnt <= '0;
    else if (strobe.winLoad)
      winCnt <= winLen;
    else if (winCnt != '0)
      winCnt <= winCnt - 1'b1;
  end

  assign calBusy = (winCnt != '0);
  assign winLast = (winCnt == WIN_W'(1));

  // re-init qualifier: saturating run-length count of initReq
  always_ff @(posedge clk) begin
    if (!rstN || !initReq)
      qCnt <= '0;
    else if (qCnt != Q_W'(REINIT_MIN))
      qCnt <= qCnt + 1'b1;
  end

  assign qualHit = (qCnt == Q_W'(REINIT_MIN));

  // a loaded window is busy on the next cycle
  p_load_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.winLoad && !strobe.winClr) |=> calBusy);

  // timer restart cannot hit on the following cycle
  p_restart_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tmrClr |=> !periodHit || (CYC_PER_US * PERIOD_US == 1));

  // qualification only while the input is still high
  p_qual_input_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qualHit) |-> $past(initReq));

endmodule

// File: rtl/zq_ctrl.sv
module zq_ctrl
  import zq_sched_pkg::*;
#(
  parameter bit LONG_PERIODIC = 1'b0,
  parameter bit USER_CAL_EN   = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        userReq,
  input  logic        calGnt,
  input  logic        periodHit,
  input  logic        winLast,
  input  logic        qualHit,
  input  logic        calBusy,
  output ctrlStrobe_t strobe,
  output logic        calReq,
  output logic        cmdType
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_BUSY = 2'd2,
    ST_HOLD = 2'd3
  } state_e;

  state_e  state, stateNext;
  logic    needInit, needInitNext;
  logic    userTrig;
  logic    trig;
  winSel_e perSel;

  generate
    if (USER_CAL_EN) begin : g_user
      assign userTrig = userReq;
    end else begin : g_nouser
      assign userTrig = 1'b0;
    end
    if (LONG_PERIODIC) begin : g_long
      assign perSel = WIN_LONG;
    end else begin : g_short
      assign perSel = WIN_SHORT;
    end
  endgenerate

  assign trig = periodHit || userTrig;

  always_comb begin
    stateNext      = state;
    needInitNext   = needInit;
    strobe.tmrClr  = 1'b0;
    strobe.winLoad = 1'b0;
    strobe.winClr  = 1'b0;
    strobe.winSel  = needInit ? WIN_INIT : perSel;
    if (qualHit) begin
      stateNext     = ST_HOLD;
      needInitNext  = 1'b1;
      strobe.winClr = 1'b1;
      strobe.tmrClr = 1'b1;
    end else begin
      unique case (state)
        ST_HOLD: begin
          strobe.tmrClr = 1'b1;
          stateNext     = ST_REQ;
        end
        ST_IDLE: if (trig) stateNext = ST_REQ;
        ST_REQ: if (calGnt) begin
          stateNext      = ST_BUSY;
          strobe.winLoad = 1'b1;
          strobe.tmrClr  = 1'b1;
          needInitNext   = 1'b0;
        end
        default: if (winLast) stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_HOLD;
      needInit <= 1'b1;
    end else begin
      state    <= stateNext;
      needInit <= needInitNext;
    end
  end

  assign calReq  = (state == ST_REQ);
  assign cmdType = needInit || LONG_PERIODIC;

  p_req_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    (calReq && !calGnt && !qualHit) |=> calReq);

  p_cmd_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (calReq && !calGnt && !qualHit) |=> $stable(cmdType));

  p_no_req_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(calReq && calBusy));

  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    qualHit |=> (!calReq && !calBusy));

  p_first_long_r8: assert property (@(posedge clk) disable iff (!rstN)
    (calReq && $past(state) == ST_HOLD) |-> cmdType);

endmodule

// File: rtl/zq_cal_sched.sv
module zq_cal_sched
  import zq_sched_pkg::*;
#(
  parameter int CYC_PER_US    = 400,
  parameter int PERIOD_US     = 200,
  parameter int T_ZQINIT      = 512,
  parameter int T_ZQCS        = 64,
  parameter int REINIT_MIN    = 4,
  parameter bit LONG_PERIODIC = 1'b0,
  parameter bit USER_CAL_EN   = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic initReq,
  input  logic userReq,
  input  logic calGnt,
  output logic calReq,
  output logic cmdType,
  output logic calBusy
);

  ctrlStrobe_t strobe;
  logic        periodHit;
  logic        winLast;
  logic        qualHit;

  zq_ctrl #(
    .LONG_PERIODIC(LONG_PERIODIC),
    .USER_CAL_EN  (USER_CAL_EN)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .userReq  (userReq),
    .calGnt   (calGnt),
    .periodHit(periodHit),
    .winLast  (winLast),
    .qualHit  (qualHit),
    .calBusy  (calBusy),
    .strobe   (strobe),
    .calReq   (calReq),
    .cmdType  (cmdType)
  );

  zq_dpath #(
    .CYC_PER_US(CYC_PER_US),
    .PERIOD_US (PERIOD_US),
    .T_ZQINIT  (T_ZQINIT),
    .T_ZQCS    (T_ZQCS),
    .REINIT_MIN(REINIT_MIN)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .initReq  (initReq),
    .strobe   (strobe),
    .periodHit(periodHit),
    .winLast  (winLast),
    .qualHit  (qualHit),
    .calBusy  (calBusy)
  );

endmodule

// File: tb/test_zq_cal_sched.sv
module test_zq_cal_sched;

  localparam int CPU   = 4;
  localparam int PUS   = 150;
  localparam int PCYC  = CPU * PUS;
  localparam int WINIT = 512;
  localparam int WCS   = 64;
  localparam int WLONG = 256;

  logic clk = 1'b0;
  logic rstN;
  logic initReq, userReq;
  logic gntA, gntB;
  logic reqA, cmdA, busyA;
  logic reqB, cmdB, busyB;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  int gCycA = 0, gCycB = 0;
  int grantsA = 0, grantsB = 0;
  int runA = 0, runB = 0;
  int winExpA = 0, winExpB = 0;
  int dlyA = 0;
  bit expInitA = 1'b1, expInitB = 1'b1;
  bit userPendA = 1'b0, skipA = 1'b0;
  logic pReqA = 0, pCmdA = 0, pBusyA = 0, pGntA = 0;
  logic pReqB = 0, pBusyB = 0;

  always #5 clk = ~clk;

  zq_cal_sched #(.CYC_PER_US(CPU), .PERIOD_US(PUS), .T_ZQINIT(WINIT), .T_ZQCS(WCS),
                 .LONG_PERIODIC(1'b0), .USER_CAL_EN(1'b1)) i_zq_cal_sched (
    .clk(clk), .rstN(rstN), .initReq(initReq), .userReq(userReq), .calGnt(gntA),
    .calReq(reqA), .cmdType(cmdA), .calBusy(busyA));

  zq_cal_sched #(.CYC_PER_US(CPU), .PERIOD_US(PUS), .T_ZQINIT(WINIT), .T_ZQCS(WCS),
                 .LONG_PERIODIC(1'b1), .USER_CAL_EN(1'b0)) i_zq_cal_sched_b (
    .clk(clk), .rstN(rstN), .initReq(1'b0), .userReq(userReq), .calGnt(gntB),
    .calReq(reqB), .cmdType(cmdB), .calBusy(busyB));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int expWin(input bit init, input bit longP);
    return init ? WINIT : (longP ? WLONG : WCS);
  endfunction

  // arbiter model: A grants after a random delay, B at once
  always @(posedge clk) begin
    #2;
    if (gntA) gntA = 1'b0;
    else if (reqA && rstN) begin
      if (dlyA == 0) begin gntA = 1'b1; dlyA = $urandom_range(0, 3); end
      else dlyA--;
    end
    if (gntB) gntB = 1'b0;
    else if (reqB && rstN) gntB = 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      // instance A
      if (reqA && busyA) chk(0, "R6 req during busy", 1, 0);
      if (reqA && !pReqA) begin
        chk(cmdA == expInitA, "R1 R8 R4 cmdType at request", cmdA, expInitA);
        if (!expInitA && !userPendA) chk(cyc - gCycA == PCYC + 1, "R4 R6 period A", cyc - gCycA, PCYC + 1);
        userPendA = 1'b0;
      end
      if (reqA && pReqA) chk(cmdA == pCmdA, "R2 cmdType stable", cmdA, pCmdA);
      if (pReqA && !reqA) chk(pGntA, "R2 request dropped without grant", 0, 1);
      if (gntA && reqA) begin
        gCycA = cyc; winExpA = expWin(expInitA, 1'b0); expInitA = 1'b0; grantsA++; runA = 0;
      end
      if (busyA) runA++;
      if (!busyA && pBusyA) begin
        if (skipA) skipA = 1'b0;
        else chk(runA == winExpA, "R3 busy length A", runA, winExpA);
      end
      // instance B
      if (reqB && busyB) chk(0, "R6 req during busy B", 1, 0);
      if (reqB && !pReqB) begin
        chk(cmdB == 1'b1, "R4 long periodic type B", cmdB, 1);
        if (!expInitB) chk(cyc - gCycB == PCYC + 1, "R5 R4 period B (user ignored)", cyc - gCycB, PCYC + 1);
      end
      if (gntB && reqB) begin
        gCycB = cyc; winExpB = expWin(expInitB, 1'b1); expInitB = 1'b0; grantsB++; runB = 0;
      end
      if (busyB) runB++;
      if (!busyB && pBusyB) chk(runB == winExpB, "R3 busy length B", runB, winExpB);
      pReqA = reqA; pCmdA = cmdA; pBusyA = busyA; pGntA = gntA;
      pReqB = reqB; pBusyB = busyB;
    end
  end

  task automatic waitGrant(input int n);
    while (grantsA < n) @(negedge clk);
  endtask

  task automatic waitBusyEnd;
    while (!busyA) @(negedge clk);
    while (busyA) @(negedge clk);
  endtask

  task automatic pulseInit(input int len);
    initReq = 1'b1;
    repeat (len) @(negedge clk);
    initReq = 1'b0;
  endtask

  task automatic qualify;
    skipA = busyA;
    expInitA = 1'b1;
    initReq = 1'b1;
    repeat (5) @(negedge clk);
    chk(!reqA && !busyA, "R7 quiet after qualify", {reqA, busyA}, 0);
    repeat (3) @(negedge clk);
    chk(!reqA && !busyA, "R7 quiet while held", {reqA, busyA}, 0);
    initReq = 1'b0;
    @(negedge clk);
    chk(!reqA, "R8 no request one edge after release", reqA, 0);
    @(negedge clk);
    chk(reqA && cmdA, "R8 long request after release", {reqA, cmdA}, 3);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; initReq = 1'b0; userReq = 1'b0; gntA = 1'b0; gntB = 1'b0;
    repeat (4) @(negedge clk);
    chk(!reqA && !busyA, "R1 reset outputs A", {reqA, busyA}, 0);
    chk(!reqB && !busyB, "R1 reset outputs B", {reqB, busyB}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqA && cmdA, "R1 long request after reset", {reqA, cmdA}, 3);
    waitGrant(1);
    repeat (10) @(negedge clk);
    userReq = 1'b1; @(negedge clk); userReq = 1'b0;   // R6 merged
    repeat (5) @(negedge clk);
    pulseInit(3);                                      // R7 short pulse in busy
    waitGrant(2);
    for (int i = 0; i < 6; i++) begin
      int n;
      n = grantsA;
      waitBusyEnd();
      repeat ($urandom_range(5, 300)) @(negedge clk);
      if (i % 3 == 0) begin
        userPendA = 1'b1;
        userReq = 1'b1; @(negedge clk); userReq = 1'b0;
        chk(reqA || grantsA > n, "R5 user request raises calReq", reqA, 1);
      end else if (i % 3 == 1) begin
        pulseInit(3);
        for (int k = 0; k < 20; k++) begin
          @(negedge clk);
          chk(!reqA && !busyA, "R7 short pulse ignored in idle", {reqA, busyA}, 0);
        end
      end
      waitGrant(n + 1);
    end
    repeat (20) @(negedge clk);
    qualify();                                         // during busy
    waitGrant(grantsA + 1);
    waitBusyEnd();
    repeat ($urandom_range(5, 200)) @(negedge clk);
    qualify();                                         // during idle
    waitGrant(grantsA + 1);
    waitGrant(grantsA + 1);
    waitBusyEnd();
    while (grantsB < 5) @(negedge clk);
    repeat (300) @(negedge clk);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(150000 * 10);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule